// File: doc/BRIEF.md
# Trip Circuit Supervision Monitor

This block watches a breaker trip circuit through two binary status inputs. One input is wired across the trip relay contact. The other is wired across the breaker auxiliary contact. Both inputs are asynchronous. Each passes through a two-flop synchronizer. A divider then produces an interrogation strobe at a fixed interval, 500 ms by default. Only at that strobe are the two synchronized levels taken as one sample.

A sample is a failure only when both inputs read low. A healthy circuit shows that state only for a moment, while the relay has closed and the breaker has not yet opened. If the state lasts, the trip circuit is broken or shorted, the supply is lost, or the mechanism has jammed. A small state machine counts consecutive samples:

- `ST_CLEAR` → `ST_ARMING` on a failing sample.
- `ST_ARMING` → `ST_TRIPPED` when the run reaches the confirm count, which raises the alarm.
- `ST_ARMING` → `ST_CLEAR` on any healthy sample.
- `ST_TRIPPED` → `ST_RELEASING` on a healthy sample.
- `ST_RELEASING` → `ST_CLEAR` when the healthy run reaches the confirm count, which drops the alarm.
- `ST_RELEASING` → `ST_TRIPPED` on any failing sample.

Top module: `trip_supervisor`

## Requirements
- R1: `sample_o` is high for exactly one cycle every `TICK_CYCLES` clock cycles. Its first pulse comes `TICK_CYCLES` rising edges after reset is released.
- R2: A sample is a failure only when `relay_in`=0 and `breaker_in`=0. The combinations (1,0), (1,1) and (0,1) are healthy.
- R3: `alarm_o` rises in the cycle after the strobe that completes `CONFIRM` (default 3) consecutive failing samples.
- R4: While the alarm is low, a healthy sample restarts the failing run. A shorter run of failures never raises the alarm.
- R5: `alarm_o` falls in the cycle after the strobe that completes `CONFIRM` consecutive healthy samples.
- R6: While the alarm is high, a failing sample restarts the healthy run and the alarm stays high.
- R7: `alarm_o` changes only in the cycle right after a strobe cycle.
- R8: During reset and right after it, `alarm_o` and `sample_o` are 0.
- R9: An input level that lasts only between two strobes and has returned before the next strobe has no effect on `alarm_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| relay_in | input | 1 | Asynchronous level across the trip relay contact |
| breaker_in | input | 1 | Asynchronous level across the breaker auxiliary contact |
| alarm_o | output | 1 | Trip circuit failure alarm |
| sample_o | output | 1 | One-cycle interrogation strobe |

## Verification
The checker watches four things on every cycle:
- the strobe spacing and its single-cycle width;
- that the alarm moves only right after a strobe;
- that an alarm rise follows a failing synchronized sample;
- that an alarm fall follows a healthy one.

Only the bench scenarios can show the counting behaviour. These scenarios cover exactly three failures being needed, interrupted runs restarting in either direction, the three healthy combinations, and mid-interval glitches being ignored. Each is checked against a reference model of the consecutive count.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    // Supervision state: counting up to alarm, or counting down to release.
    typedef enum logic [1:0] {
        ST_CLEAR     = 2'd0,
        ST_ARMING    = 2'd1,
        ST_TRIPPED   = 2'd2,
        ST_RELEASING = 2'd3
    } tcs_state_t;

    // A sample is a failure only when neither contact path carries voltage (R2).
    function automatic logic is_failure(input logic relay_lvl, input logic breaker_lvl);
        return (relay_lvl == 1'b0) && (breaker_lvl == 1'b0);
    endfunction

    function automatic logic alarm_of(input tcs_state_t st);
        return (st == ST_TRIPPED) || (st == ST_RELEASING);
    endfunction

endpackage

// File: rtl/tcs_sync.sv
module tcs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/tcs_tick.sv
module tcs_tick #(
    parameter int TICK_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int TW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

    logic [TW-1:0] cnt_q;
    logic          tick_q;

    // Counter wraps every TICK_CYCLES cycles; the strobe is registered so the
    // first pulse lands a full interval after reset (R1).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= (cnt_q == LAST);
            if (cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/tcs_confirm_fsm.sv
module tcs_confirm_fsm
    import tcs_pkg::*;
#(
    parameter int CONFIRM = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic relay_s,
    input  logic breaker_s,
    output logic alarm_o
);

    localparam int CW = $clog2(CONFIRM + 1);
    localparam logic [CW-1:0] GOAL = CW'(CONFIRM);

    tcs_state_t    state_q, state_d;
    logic [CW-1:0] run_q, run_d;
    logic          alarm_q;
    logic          fail;
    logic [CW-1:0] run_inc;

    assign fail    = is_failure(relay_s, breaker_s);
    assign run_inc = (run_q == GOAL) ? run_q : run_q + 1'b1;

    // Next state and consecutive-sample run length (R3..R6).
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (sample_i) begin
            unique case (state_q)
                ST_CLEAR: begin
                    if (fail) begin
                        run_d   = CW'(1);
                        state_d = (GOAL == CW'(1)) ? ST_TRIPPED : ST_ARMING;
                        if (GOAL == CW'(1)) run_d = '0;
                    end else begin
                        run_d = '0;
                    end
                end
                ST_ARMING: begin
                    if (fail) begin
                        if (run_inc == GOAL) begin
                            state_d = ST_TRIPPED;
                            run_d   = '0;
                        end else begin
                            run_d = run_inc;
                        end
                    end else begin
                        state_d = ST_CLEAR;
                        run_d   = '0;
                    end
                end
                ST_TRIPPED: begin
                    if (!fail) begin
                        run_d   = CW'(1);
                        state_d = (GOAL == CW'(1)) ? ST_CLEAR : ST_RELEASING;
                        if (GOAL == CW'(1)) run_d = '0;
                    end else begin
                        run_d = '0;
                    end
                end
                ST_RELEASING: begin
                    if (!fail) begin
                        if (run_inc == GOAL) begin
                            state_d = ST_CLEAR;
                            run_d   = '0;
                        end else begin
                            run_d = run_inc;
                        end
                    end else begin
                        state_d = ST_TRIPPED;
                        run_d   = '0;
                    end
                end
                default: begin
                    state_d = ST_CLEAR;
                    run_d   = '0;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // Output register: alarm follows the state being entered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
        end else begin
            alarm_q <= alarm_of(state_d);
        end
    end

    assign alarm_o = alarm_q;

endmodule

// File: rtl/trip_supervisor.sv
module trip_supervisor #(
    parameter int TICK_CYCLES = 25_000_000,
    parameter int CONFIRM     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic relay_in,
    input  logic breaker_in,
    output logic alarm_o,
    output logic sample_o
);

    logic [1:0] sync_bits;
    logic       relay_s;
    logic       breaker_s;
    logic       tick;

    tcs_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({breaker_in, relay_in}),
        .sync_o  (sync_bits)
    );

    assign relay_s   = sync_bits[0];
    assign breaker_s = sync_bits[1];

    tcs_tick #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    tcs_confirm_fsm #(
        .CONFIRM (CONFIRM)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  (tick),
        .relay_s   (relay_s),
        .breaker_s (breaker_s),
        .alarm_o   (alarm_o)
    );

    assign sample_o = tick;

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
    parameter int TICK_CYCLES = 25_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic sample_o,
    input logic alarm_o,
    input logic relay_s,
    input logic breaker_s
);

    localparam int GW = $clog2(TICK_CYCLES + 1) + 1;

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else begin
            gap_q <= sample_o ? GW'(1) : gap_q + 1'b1;
        end
    end

    a_r1_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o);

    a_r1_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> (gap_q == GW'(TICK_CYCLES)));

    a_r7_alarm_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(alarm_o) |-> $past(sample_o));

    a_r3_rise_on_failure: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> ($past(relay_s) == 1'b0 && $past(breaker_s) == 1'b0));

    a_r5_fall_on_healthy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_o) |-> ($past(relay_s) == 1'b1 || $past(breaker_s) == 1'b1));

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r8_reset_quiet: assert (alarm_o == 1'b0 && sample_o == 1'b0);
        end
    end

endmodule

bind trip_supervisor tcs_checker #(
    .TICK_CYCLES (TICK_CYCLES)
) u_tcs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_o  (sample_o),
    .alarm_o   (alarm_o),
    .relay_s   (relay_s),
    .breaker_s (breaker_s)
);

// File: tb/trip_supervisor_bench.sv
module trip_supervisor_bench;

    localparam int TICK    = 16;
    localparam int CONFIRM = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic relay_in = 1'b1;
    logic breaker_in = 1'b0;
    logic alarm_o;
    logic sample_o;

    int n_checks = 0;
    int n_fail = 0;
    int m_alarm = 0;
    int m_run = 0;
    int since_strobe = 0;

    always #10 clk = ~clk;

    trip_supervisor #(
        .TICK_CYCLES (TICK),
        .CONFIRM     (CONFIRM),
        .SYNC_STAGES (2)
    ) u_trip_supervisor (
        .clk        (clk),
        .rst_n      (rst_n),
        .relay_in   (relay_in),
        .breaker_in (breaker_in),
        .alarm_o    (alarm_o),
        .sample_o   (sample_o)
    );

    // Reference model: returns {alarm, run} after one sample (R2..R6).
    function automatic logic [8:0] model_step(input int alarm, input int run,
                                              input logic r, input logic b);
        logic f;
        int a2, r2;
        f  = (r == 1'b0) && (b == 1'b0);
        a2 = alarm;
        r2 = run;
        if (alarm == 0) begin
            if (f) begin
                r2 = run + 1;
                if (r2 == CONFIRM) begin a2 = 1; r2 = 0; end
            end else r2 = 0;
        end else begin
            if (!f) begin
                r2 = run + 1;
                if (r2 == CONFIRM) begin a2 = 0; r2 = 0; end
            end else r2 = 0;
        end
        return {a2[0], r2[7:0]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One interrogation: hold (r,b), optionally glitch both low mid-interval.
    task automatic do_sample(input logic r, input logic b, input bit glitch,
                             input string req);
        logic [8:0] nx;
        int gap;
        relay_in   = r;
        breaker_in = b;
        gap = since_strobe;
        if (glitch) begin
            repeat (5) begin @(negedge clk); gap++; end
            relay_in   = 1'b0;
            breaker_in = 1'b0;
            repeat (3) begin @(negedge clk); gap++; end
            relay_in   = r;
            breaker_in = b;
        end
        do begin
            @(negedge clk);
            gap++;
        end while (!sample_o && gap < 4 * TICK);
        check(sample_o == 1'b1 && gap == TICK, "R1 strobe spacing", gap, TICK);
        nx = model_step(m_alarm, m_run, r, b);
        @(negedge clk);
        since_strobe = 1;
        check(sample_o == 1'b0, "R1 strobe width", int'(sample_o), 0);
        m_alarm = int'(nx[8]);
        m_run   = int'(nx[7:0]);
        check(alarm_o == nx[8], req, int'(alarm_o), m_alarm);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(alarm_o == 1'b0, "R8 alarm in reset", int'(alarm_o), 0);
        check(sample_o == 1'b0, "R8 strobe in reset", int'(sample_o), 0);
        rst_n = 1'b1;
        since_strobe = 0;
        check(alarm_o == 1'b0, "R8 alarm after reset", int'(alarm_o), 0);

        // R2: every healthy combination keeps the alarm low.
        do_sample(1'b1, 1'b0, 1'b0, "R2 relay open breaker closed");
        do_sample(1'b1, 1'b1, 1'b0, "R2 both high");
        do_sample(1'b0, 1'b1, 1'b0, "R2 relay closed breaker open");
        // R4: runs of two failures broken by healthy samples.
        do_sample(1'b0, 1'b0, 1'b0, "R4 fail 1");
        do_sample(1'b0, 1'b0, 1'b0, "R4 fail 2");
        do_sample(1'b0, 1'b1, 1'b0, "R4 restart");
        do_sample(1'b0, 1'b0, 1'b0, "R4 fail 1 again");
        do_sample(1'b0, 1'b0, 1'b0, "R4 fail 2 again");
        do_sample(1'b1, 1'b0, 1'b0, "R4 restart again");
        // R3: three in a row raise the alarm.
        do_sample(1'b0, 1'b0, 1'b0, "R3 fail 1");
        do_sample(1'b0, 1'b0, 1'b0, "R3 fail 2");
        do_sample(1'b0, 1'b0, 1'b0, "R3 fail 3 alarm");
        check(alarm_o == 1'b1, "R3 alarm raised", int'(alarm_o), 1);
        // R6: failure during recovery restarts the healthy run.
        do_sample(1'b1, 1'b1, 1'b0, "R6 healthy 1");
        do_sample(1'b1, 1'b1, 1'b0, "R6 healthy 2");
        do_sample(1'b0, 1'b0, 1'b0, "R6 fail keeps alarm");
        check(alarm_o == 1'b1, "R6 alarm held", int'(alarm_o), 1);
        // R5: three healthy in a row clear it.
        do_sample(1'b1, 1'b0, 1'b0, "R5 healthy 1");
        do_sample(1'b1, 1'b1, 1'b0, "R5 healthy 2");
        do_sample(1'b0, 1'b1, 1'b0, "R5 healthy 3 clear");
        check(alarm_o == 1'b0, "R5 alarm cleared", int'(alarm_o), 0);
        // R9: mid-interval both-low glitches are never sampled.
        for (int k = 0; k < 4; k++) begin
            do_sample(1'b1, 1'b0, 1'b1, "R9 glitch ignored");
        end
        check(alarm_o == 1'b0, "R9 alarm still low", int'(alarm_o), 0);
        // Random mix of failing and healthy samples.
        for (int k = 0; k < 80; k++) begin
            int pick;
            pick = int'($urandom_range(0, 9));
            if (pick < 5)      do_sample(1'b0, 1'b0, 1'b0, "R3 random");
            else if (pick < 7) do_sample(1'b1, 1'b0, 1'b0, "R5 random");
            else if (pick < 9) do_sample(1'b1, 1'b1, 1'b0, "R5 random");
            else               do_sample(1'b0, 1'b1, 1'b1, "R9 random");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule